// File: doc/BRIEF.md
# Adaptive-Resolution Processor Core with Popcount

This block is a small SIMD-style processor whose 16-bit datapath can be cut at run time into independent lanes of any width, from sixteen 1-bit lanes up to one 16-bit lane. Each instruction supplies a per-bit lane-join mask. Bit i set means bit i takes the carry out of bit i-1. Bit i clear starts a new lane at bit i. Bit 0 always starts a lane. The same hardware therefore runs either many narrow additions or fewer wide ones. A population-count unit sums the sixteen 1-bit lanes of an operand into one number. It is used after bitwise work on binary data, such as matching a bit-plane against a template.

Instructions arrive one 32-bit word at a time over a valid/ready input. A control state machine steps through fetch, decode, execute and writeback, so it accepts a new word every fourth cycle. Operands come from a bank of sixteen 16-bit registers with two read ports and one write port. A result goes either back into the bank or out through a one-cycle external memory write strobe, tagged with the destination field.

Top module: `flexproc_core`

## Requirements
- R1: While reset is held and right after it, `in_ready` is 1 and `mem_we` is 0, and every register of the bank reads as zero.
- R2: The word layout is cmd [31:30], imm [29:14], src_a [13:10], src_b [9:6], to_mem [5], dst [4:1], pick [0]. Command 00 writes imm into register dst. It always goes to the bank, whatever to_mem and pick hold, and it raises no memory strobe.
- R3: Command 10 produces the bitwise AND of registers src_a and src_b. The lane-join mask and the pick bit have no effect on it.
- R4: Command 11 with pick=0 adds src_a and src_b lane by lane. imm bit i (1..15) set joins bit i to the carry of bit i-1, and imm bit 0 has no effect. The carry out of a lane's top bit is dropped.
- R5: Command 11 with pick=1 yields the number of ones in register src_a, zero-extended to 16 bits (0 to 16). Register src_b has no effect.
- R6: For commands 10 and 11, to_mem=1 raises `mem_we` for exactly one cycle with the result on `mem_data` and dst on `mem_tag`, and the bank is left unchanged. to_mem=0 writes the result to register dst with no strobe.
- R7: Command 01 writes no register and raises no strobe, whatever to_mem and dst hold.
- R8: A word is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays low for three cycles, so at most one word is taken per four cycles. Any strobe for that word is high in the cycle that follows the third edge after acceptance.
- R9: A register written by one instruction holds the new value when the next instruction reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction word is offered |
| in_ready | output | 1 | The core can take a word this cycle |
| in_instr | input | 32 | Instruction word |
| mem_we | output | 1 | One-cycle external write strobe |
| mem_data | output | 16 | Result sent to external memory |
| mem_tag | output | 4 | Destination field of the strobed result |

## Verification
The segmented adder is driven with the same operands under several masks: all lanes one bit wide, one full-width lane, 4-bit lanes and 8-bit lanes. One case uses a mask whose bit 0 is set. A missing or misplaced carry cut changes the sum in at least one of these cases. Popcount is fed all-zero, all-one and two-bit patterns, with src_b holding something different each time, so a count taken from the wrong operand or clipped below 16 shows up. AND is tried with a non-zero mask and with pick set to show that neither reaches it. Directed cases tell memory writes apart from bank writes, check the no-op command and check back-to-back read-after-write. A continuous stream of offered words pins down the acceptance rate and the cycle in which the strobe appears.

// File: rtl/flexproc_pkg.sv
package flexproc_pkg;
  localparam int DEF_DW = 16;
  localparam int DEF_AW = 4;

  typedef enum logic [1:0] {
    CMD_LOAD = 2'b00,
    CMD_CFG  = 2'b01,
    CMD_AND  = 2'b10,
    CMD_ADD  = 2'b11
  } cmd_t;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_DEC   = 2'd1,
    ST_EXEC  = 2'd2,
    ST_WB    = 2'd3
  } state_t;
endpackage

// File: rtl/flexproc_regbank.sv
module flexproc_regbank #(
  parameter int DW   = 16,
  parameter int AW   = 4,
  localparam int NREG = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_addr,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_a_data,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && wr_addr == AW'(g))
        regs[g] <= wr_data;
    end
  end

  assign rd_a_data = regs[rd_a_addr];
  assign rd_b_data = regs[rd_b_addr];
endmodule

// File: rtl/flexproc_seg_alu.sv
module flexproc_seg_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:1] join_mask,
  input  logic          do_add,
  output logic [DW-1:0] result
);
  logic [DW-1:0] cin;
  logic [DW-1:0] cout;
  logic [DW-1:0] sum;

  function automatic logic carry_of(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a ^ b));
  endfunction

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign cin[i] = 1'b0;
    end else begin : g_rest
      assign cin[i] = join_mask[i] & cout[i-1];
    end
    assign sum[i]  = op_a[i] ^ op_b[i] ^ cin[i];
    assign cout[i] = carry_of(op_a[i], op_b[i], cin[i]);
  end

  assign result = do_add ? sum : (op_a & op_b);
endmodule

// File: rtl/flexproc_popcnt.sv
module flexproc_popcnt #(
  parameter int DW = 16,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic [DW-1:0] bits,
  output logic [CW-1:0] count
);
  function automatic logic [CW-1:0] ones_in(input logic [DW-1:0] v);
    logic [CW-1:0] acc;
    acc = '0;
    for (int k = 0; k < DW; k++) acc = acc + CW'(v[k]);
    return acc;
  endfunction

  assign count = ones_in(bits);
endmodule

// File: rtl/flexproc_core.sv
module flexproc_core
  import flexproc_pkg::*;
#(
  parameter int DATA_W = DEF_DW,
  parameter int ADDR_W = DEF_AW,
  localparam int INSTR_W = 2 + DATA_W + 3 * ADDR_W + 2,
  localparam int CNT_W   = $clog2(DATA_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  output logic               mem_we,
  output logic [DATA_W-1:0]  mem_data,
  output logic [ADDR_W-1:0]  mem_tag
);
  localparam int DST_LO  = 1;
  localparam int OUT_BIT = ADDR_W + 1;
  localparam int SRCB_LO = ADDR_W + 2;
  localparam int SRCA_LO = 2 * ADDR_W + 2;
  localparam int IMM_LO  = 3 * ADDR_W + 2;

  state_t              st_q;
  logic [INSTR_W-1:0]  ir_q;
  logic [DATA_W-1:0]   opa_q, opb_q, res_q;
  logic [DATA_W-1:1]   cfg_q;

  cmd_t                ir_cmd;
  logic [DATA_W-1:0]   ir_imm;
  logic [ADDR_W-1:0]   ir_srca, ir_srcb, ir_dst;
  logic                ir_out, ir_pick;

  logic                accept;
  logic                rf_we;
  logic [DATA_W-1:0]   rd_a, rd_b;
  logic [DATA_W-1:0]   alu_y;
  logic [CNT_W-1:0]    pop_value;
  logic [DATA_W-1:0]   exec_value;
  logic                is_alu;

  assign ir_cmd  = cmd_t'(ir_q[INSTR_W-1 -: 2]);
  assign ir_imm  = ir_q[IMM_LO +: DATA_W];
  assign ir_srca = ir_q[SRCA_LO +: ADDR_W];
  assign ir_srcb = ir_q[SRCB_LO +: ADDR_W];
  assign ir_out  = ir_q[OUT_BIT];
  assign ir_dst  = ir_q[DST_LO +: ADDR_W];
  assign ir_pick = ir_q[0];

  assign in_ready = (st_q == ST_FETCH);
  assign accept   = in_valid && in_ready;
  assign is_alu   = (ir_cmd == CMD_AND) || (ir_cmd == CMD_ADD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FETCH;
      ir_q  <= '0;
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
      cfg_q <= '0;
    end else begin
      unique case (st_q)
        ST_FETCH: if (accept) begin
          ir_q <= in_instr;
          st_q <= ST_DEC;
        end
        ST_DEC: begin
          opa_q <= rd_a;
          opb_q <= rd_b;
          if (ir_cmd != CMD_LOAD) cfg_q <= ir_imm[DATA_W-1:1];
          st_q  <= ST_EXEC;
        end
        ST_EXEC: begin
          res_q <= exec_value;
          st_q  <= ST_WB;
        end
        default: st_q <= ST_FETCH;
      endcase
    end
  end

  flexproc_regbank #(.DW(DATA_W), .AW(ADDR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_addr (ir_srca),
    .rd_b_addr (ir_srcb),
    .rd_a_data (rd_a),
    .rd_b_data (rd_b),
    .wr_en     (rf_we),
    .wr_addr   (ir_dst),
    .wr_data   (res_q)
  );

  flexproc_seg_alu #(.DW(DATA_W)) u_alu (
    .op_a      (opa_q),
    .op_b      (opb_q),
    .join_mask (cfg_q),
    .do_add    (ir_cmd == CMD_ADD),
    .result    (alu_y)
  );

  flexproc_popcnt #(.DW(DATA_W)) u_pop (
    .bits  (opa_q),
    .count (pop_value)
  );

  always_comb begin
    unique case (ir_cmd)
      CMD_LOAD: exec_value = ir_imm;
      CMD_AND:  exec_value = alu_y;
      CMD_ADD:  exec_value = ir_pick ? DATA_W'(pop_value) : alu_y;
      default:  exec_value = '0;
    endcase
  end

  assign rf_we    = (st_q == ST_WB) && ((ir_cmd == CMD_LOAD) || (is_alu && !ir_out));
  assign mem_we   = (st_q == ST_WB) && is_alu && ir_out;
  assign mem_data = res_q;
  assign mem_tag  = ir_dst;
endmodule

// File: rtl/flexproc_core_chk.sv
module flexproc_core_chk #(
  parameter int IW = 32,
  parameter int DW = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [IW-1:0] in_instr,
  input logic          mem_we,
  input logic          rf_we,
  input logic [CW-1:0] pop_value
);
  logic take;
  assign take = in_valid && in_ready;

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (in_ready && !mem_we && !rf_we);
    end
  end

  assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);

  assert_strobe_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(take, 3));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_one_sink_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && rf_we));

  assert_pop_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_value <= CW'(DW));

  assert_cfg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_instr[IW-1 -: 2] == 2'b01) |=> ##2 (!mem_we && !rf_we));
endmodule

bind flexproc_core flexproc_core_chk #(.IW(INSTR_W), .DW(DATA_W), .CW(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_instr  (in_instr),
  .mem_we    (mem_we),
  .rf_we     (rf_we),
  .pop_value (pop_value)
);

// File: tb/flexproc_core_test.sv
module flexproc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        mem_we;
  logic [15:0] mem_data;
  logic [3:0]  mem_tag;

  int errors = 0;
  int checks = 0;
  int strobes = 0;
  logic [15:0] last_data = '0;
  logic [3:0]  last_tag = '0;

  always #10 clk = ~clk;

  flexproc_core uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_instr (in_instr), .mem_we (mem_we), .mem_data (mem_data), .mem_tag (mem_tag)
  );

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      strobes   <= strobes + 1;
      last_data <= mem_data;
      last_tag  <= mem_tag;
    end
  end

  // op: 0 AND, 1 AND with pick set, 2 segmented ADD, 3 popcount
  localparam logic [49:0] VEC [11] = '{
    {2'd0, 16'hF0F0, 16'hFF00, 16'h1234},
    {2'd1, 16'hAAAA, 16'h0FF0, 16'hFFFE},
    {2'd2, 16'hFFFF, 16'h0001, 16'h0000},
    {2'd2, 16'hFFFF, 16'h0001, 16'hFFFE},
    {2'd2, 16'hFFFF, 16'h0001, 16'hFFFF},
    {2'd2, 16'h0F0F, 16'h0111, 16'hEEEE},
    {2'd2, 16'h12FF, 16'h3401, 16'hFEFE},
    {2'd2, 16'h1234, 16'h4321, 16'hFFFE},
    {2'd3, 16'h0000, 16'hFFFF, 16'h0000},
    {2'd3, 16'hFFFF, 16'h0000, 16'h0000},
    {2'd3, 16'h8001, 16'h7FFE, 16'h0000}
  };

  function automatic logic [31:0] mk(input logic [1:0] c, input logic [15:0] imm,
      input logic [3:0] sa, input logic [3:0] sb, input logic om,
      input logic [3:0] d, input logic pk);
    return {c, imm, sa, sb, om, d, pk};
  endfunction

  // Lane-by-lane sum: each lane added as an integer, then cut to its width.
  function automatic logic [15:0] lane_sum(input logic [15:0] a, input logic [15:0] b,
      input logic [15:0] m);
    int start = 0;
    int r = 0;
    for (int i = 1; i <= 16; i++) begin
      bit brk = (i == 16);
      if (!brk) brk = !m[i];
      if (brk) begin
        int msk = (1 << (i - start)) - 1;
        int s = ((int'(a) >> start) & msk) + ((int'(b) >> start) & msk);
        r = r | ((s & msk) << start);
        start = i;
      end
    end
    return r[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins);
    @(negedge clk);
    in_instr = ins;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic peek(input logic [3:0] r, input logic [15:0] exp, input string req);
    issue(mk(2'b10, 16'h0000, r, r, 1'b1, r, 1'b0));
    check(req, {16'h0, last_data}, {16'h0, exp});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    int k;
    int acc;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'h0, in_ready}, 32'h1);
    check("R1 strobe in reset", {31'h0, mem_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'h0, in_ready}, 32'h1);
    peek(4'd7, 16'h0000, "R1 register zero");

    for (int v = 0; v < 11; v++) begin
      logic [1:0]  op  = VEC[v][49:48];
      logic [15:0] a   = VEC[v][47:32];
      logic [15:0] b   = VEC[v][31:16];
      logic [15:0] m   = VEC[v][15:0];
      logic [15:0] exp;
      logic [3:0]  tg  = 4'(v + 3);
      string rq;
      base = strobes;
      issue(mk(2'b00, a, 4'd9, 4'd2, 1'b1, 4'd1, 1'b1));
      issue(mk(2'b00, b, 4'd0, 4'd0, 1'b0, 4'd2, 1'b0));
      check("R2 load makes no strobe", strobes - base, 0);
      case (op)
        2'd0, 2'd1: begin exp = a & b; rq = "R3 AND"; end
        2'd2:       begin exp = lane_sum(a, b, m); rq = "R4 lane add"; end
        default:    begin exp = 16'($countones(a)); rq = "R5 popcount"; end
      endcase
      issue(mk((op < 2) ? 2'b10 : 2'b11, m, 4'd1, 4'd2, 1'b1, tg, op[0]));
      check(rq, {16'h0, last_data}, {16'h0, exp});
      check("R6 tag", {28'h0, last_tag}, {28'h0, tg});
      check("R6 one strobe", strobes - base, 1);
    end

    // R6: result to bank, no strobe; then read back
    issue(mk(2'b00, 16'h00F0, 4'd0, 4'd0, 1'b0, 4'd1, 1'b0));
    issue(mk(2'b00, 16'h0F10, 4'd0, 4'd0, 1'b0, 4'd2, 1'b0));
    base = strobes;
    issue(mk(2'b11, 16'hFFFE, 4'd1, 4'd2, 1'b0, 4'd3, 1'b0));
    check("R6 bank write no strobe", strobes - base, 0);
    peek(4'd3, 16'h1000, "R6 bank write value");

    // R6: memory write leaves bank unchanged
    issue(mk(2'b00, 16'hBEEF, 4'd0, 4'd0, 1'b0, 4'd5, 1'b0));
    issue(mk(2'b10, 16'h0000, 4'd1, 4'd2, 1'b1, 4'd5, 1'b0));
    peek(4'd5, 16'hBEEF, "R6 bank untouched by memory write");

    // R7: no-op command
    base = strobes;
    issue(mk(2'b01, 16'h1234, 4'd1, 4'd2, 1'b0, 4'd5, 1'b1));
    issue(mk(2'b01, 16'hFFFF, 4'd1, 4'd2, 1'b1, 4'd5, 1'b0));
    check("R7 no strobe", strobes - base, 0);
    peek(4'd5, 16'hBEEF, "R7 register kept");

    // R9: chained read-after-write, 1 doubled three times
    issue(mk(2'b00, 16'h0001, 4'd0, 4'd0, 1'b0, 4'd4, 1'b0));
    for (int n = 0; n < 3; n++)
      issue(mk(2'b11, 16'hFFFE, 4'd4, 4'd4, 1'b0, 4'd4, 1'b0));
    peek(4'd4, 16'h0008, "R9 chained writes");

    // R8: acceptance rate under a continuous offer
    @(negedge clk);
    in_instr = mk(2'b01, 16'h0, 4'd0, 4'd0, 1'b0, 4'd0, 1'b0);
    in_valid = 1'b1;
    acc = 0;
    for (int c = 0; c < 16; c++) begin
      if (in_valid && in_ready) acc++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R8 one word per four cycles", acc, 4);
    while (!in_ready) @(negedge clk);

    // R8: strobe position and width
    in_instr = mk(2'b10, 16'h0, 4'd5, 4'd5, 1'b1, 4'd6, 1'b0);
    in_valid = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      in_valid = 1'b0;
    end while (!mem_we && k < 8);
    check("R8 strobe after third edge", k, 3);
    @(negedge clk);
    check("R8 strobe width", {31'h0, mem_we}, 32'h0);
    while (!in_ready) @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule